// File: doc/BRIEF.md
# Data EEPROM Register Controller

This block gives a small processor access to a 64-byte on-chip data EEPROM through four byte-wide registers on a simple register bus. Software puts a cell address in the address register and a byte in the data register. It then starts a read or a write through the start bits of the control register. Hardware clears each start bit when its cycle ends, so software can poll for completion. The bytes themselves are modelled by a behavioural array.

Reads take a fixed two clocks. Write time is measured by a timer that runs freely, apart from the bus, so the length of a write depends on the timer's phase. Two guards protect the cells from stray writes. The write start must come on the register access immediately after the access that sets write-enable, and write-enable is clear after reset. A finished write raises an EEPROM flag and a shared multi-function flag. The interrupt request combines these flags with three enables and a stack-room input.

The sequencer has five states:
- `ST_IDLE` waits.
- A read goes `ST_IDLE -> ST_RD_WAIT -> ST_RD_LOAD -> ST_IDLE`.
- A write goes `ST_IDLE -> ST_WR_ALIGN` (wait for the next timer wrap) `-> ST_WR_PROG` (one full timer period) `-> ST_IDLE`.

Top module: `nvb_ctrl`

## Requirements
- R1: After reset, offsets 0, 2 and 3 read zero, `busy` is 0 and `irq_req` is 0. Register map: offset 0 is the address, offset 1 the data, offset 2 the control register (bit0 write-start, bit1 read-start, bit2 write-enable, bit3 read-enable), and offset 3 the interrupt register (bit0 global enable, bit1 EEPROM enable, bit2 multi-function enable, bit4 EEPROM flag, bit5 multi-function flag).
- R2: Writing read-start while the stored read-enable is 0 starts nothing. Read-start reads back 0, `busy` stays 0 and the data register is unchanged.
- R3: A control write that sets read-start while read-enable is already 1 starts a read. Read-start and `busy` are 1 for the two clocks after that write's edge. At the second edge both are 0 and the data register holds the byte at the addressed cell.
- R4: The data register keeps its value across register reads and refused starts, until a read cycle or a data-register write changes it.
- R5: A write cycle starts only if the control write sets write-start with write-enable 1, and the stored write-enable is already 1. If write-enable is 0, or if both bits are set by a single write, write-start stays 0.
- R6: If any register access (read or write, any offset) comes between the access that sets write-enable (with write-start 0) and the access that sets write-start, the start is refused.
- R7: A write cycle keeps write-start and `busy` at 1 for between WR_CYCLES+1 and 2*WR_CYCLES clocks, counted from the timer's free-running phase. Both then clear and the addressed cell holds the data byte.
- R8: While `busy` is 1, writes to the address register, the data register and the start bits are ignored. The enable bits in the control register remain writable.
- R9: The end of a write sets both the EEPROM flag and the multi-function flag. The set wins over a software write to the flags in the same cycle.
- R10: `irq_req` is 1 exactly when all three enables and both flags are 1 and `stack_ok` is 1.
- R11: A one-cycle `irq_ack` clears only the multi-function flag. The EEPROM flag stays set until software writes it to 0.
- R12: If one control write sets both start bits while a write start is valid, the write starts and read-start stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | Access is a write |
| bus_off | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the register at `bus_off` |
| stack_ok | input | 1 | Interrupt stack has room |
| irq_ack | input | 1 | Interrupt serviced; clears the multi-function flag |
| irq_req | output | 1 | Interrupt request |
| busy | output | 1 | A read or write cycle is running |

## Verification
The end of a write sets both flags in the same cycle that a software write to the interrupt register may clear them. To provoke this, the bench rewrites the interrupt register with the flags at zero on every clock for as long as `busy` is high, so the completing edge always meets a clearing write. After `busy` falls, both flags must read back as 1. A second case lets a control write that sets both start bits compete with a read start, and it must produce only a write.

// File: rtl/nvb_pkg.sv
package nvb_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_WAIT,
        ST_RD_LOAD,
        ST_WR_ALIGN,
        ST_WR_PROG
    } nvb_state_e;

    localparam logic [1:0] OFF_ADR = 2'd0;
    localparam logic [1:0] OFF_DAT = 2'd1;
    localparam logic [1:0] OFF_CTL = 2'd2;
    localparam logic [1:0] OFF_IRQ = 2'd3;

    localparam int CB_WS = 0;
    localparam int CB_RS = 1;
    localparam int CB_WE = 2;
    localparam int CB_RE = 3;

    localparam int IB_GLB  = 0;
    localparam int IB_EEIE = 1;
    localparam int IB_MFIE = 2;
    localparam int IB_EEF  = 4;
    localparam int IB_MFF  = 5;

endpackage

// File: rtl/nvb_wtimer.sv
module nvb_wtimer #(
    parameter int WR_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic wrap
);
    localparam int CW = (WR_CYCLES > 1) ? $clog2(WR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WR_CYCLES - 1);

    logic [CW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == LAST)
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    assign wrap = (phase_q == LAST);

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST) else $error("timer phase out of range"); // R7
endmodule

// File: rtl/nvb_cells.sv
module nvb_cells #(
    parameter int AW = 6,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/nvb_seq.sv
module nvb_seq
    import nvb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_rd,
    input  logic start_wr,
    input  logic tick,
    output logic busy,
    output logic rd_done,
    output logic wr_done
);
    nvb_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_wr)
                    state_d = ST_WR_ALIGN;
                else if (start_rd)
                    state_d = ST_RD_WAIT;
            end
            ST_RD_WAIT:  state_d = ST_RD_LOAD;
            ST_RD_LOAD:  state_d = ST_IDLE;
            ST_WR_ALIGN: if (tick) state_d = ST_WR_PROG;
            ST_WR_PROG:  if (tick) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        busy    = 1'b0;
        rd_done = 1'b0;
        wr_done = 1'b0;
        unique case (state_q)
            ST_IDLE:     busy = 1'b0;
            ST_RD_WAIT:  busy = 1'b1;
            ST_RD_LOAD:  begin busy = 1'b1; rd_done = 1'b1; end
            ST_WR_ALIGN: busy = 1'b1;
            ST_WR_PROG:  begin busy = 1'b1; wr_done = tick; end
            default:     busy = 1'b0;
        endcase
    end

    AST_RD_TWO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_rd && !start_wr) |=> ##1 rd_done)
        else $error("read did not end two clocks after start"); // R3
    AST_WR_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && start_wr) |=> (state_q == ST_WR_ALIGN))
        else $error("write start not taken"); // R12
endmodule

// File: rtl/nvb_irq.sv
module nvb_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done,
    input  logic sw_we,
    input  logic sw_ee,
    input  logic sw_mf,
    input  logic ack,
    output logic ee_f,
    output logic mf_f
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ee_f <= 1'b0;
            mf_f <= 1'b0;
        end else if (set_done) begin
            ee_f <= 1'b1;
            mf_f <= 1'b1;
        end else if (sw_we) begin
            ee_f <= sw_ee;
            mf_f <= sw_mf;
        end else if (ack) begin
            mf_f <= 1'b0;
        end
    end

    AST_DONE_SETS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> (ee_f && mf_f)) else $error("flags not set at write end"); // R9
    AST_ACK_KEEPS_EE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !set_done && !sw_we) |=> ($stable(ee_f) && !mf_f))
        else $error("ack touched the EEPROM flag"); // R11
endmodule

// File: rtl/nvb_ctrl.sv
module nvb_ctrl
    import nvb_pkg::*;
#(
    parameter int AW        = 6,
    parameter int WR_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_sel,
    input  logic       bus_we,
    input  logic [1:0] bus_off,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       stack_ok,
    input  logic       irq_ack,
    output logic       irq_req,
    output logic       busy
);
    localparam int DW = 8;

    logic [AW-1:0] adr_q;
    logic [DW-1:0] dat_q;
    logic          ws_q, rs_q, we_q, re_q, arm_q;
    logic          glb_q, eeie_q, mfie_q;
    logic          ee_f, mf_f;
    logic          tick, rd_done, wr_done;
    logic [DW-1:0] cell_rdata;

    logic reg_wr, ctl_wr, irq_wr, arming_wr, start_wr, start_rd;

    assign reg_wr    = bus_sel && bus_we;
    assign ctl_wr    = reg_wr && (bus_off == OFF_CTL);
    assign irq_wr    = reg_wr && (bus_off == OFF_IRQ);
    assign arming_wr = ctl_wr && bus_wdata[CB_WE] && !bus_wdata[CB_WS];
    assign start_wr  = ctl_wr && bus_wdata[CB_WS] && bus_wdata[CB_WE]
                       && we_q && arm_q && !busy;
    assign start_rd  = ctl_wr && bus_wdata[CB_RS] && re_q && !busy && !start_wr;

    nvb_wtimer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .wrap  (tick)
    );

    nvb_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_rd (start_rd),
        .start_wr (start_wr),
        .tick     (tick),
        .busy     (busy),
        .rd_done  (rd_done),
        .wr_done  (wr_done)
    );

    nvb_cells #(.AW(AW), .DW(DW)) u_cells (
        .clk   (clk),
        .we    (wr_done),
        .waddr (adr_q),
        .wdata (dat_q),
        .raddr (adr_q),
        .rdata (cell_rdata)
    );

    nvb_irq u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_done (wr_done),
        .sw_we    (irq_wr),
        .sw_ee    (bus_wdata[IB_EEF]),
        .sw_mf    (bus_wdata[IB_MFF]),
        .ack      (irq_ack),
        .ee_f     (ee_f),
        .mf_f     (mf_f)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adr_q  <= '0;
            dat_q  <= '0;
            ws_q   <= 1'b0;
            rs_q   <= 1'b0;
            we_q   <= 1'b0;
            re_q   <= 1'b0;
            arm_q  <= 1'b0;
            glb_q  <= 1'b0;
            eeie_q <= 1'b0;
            mfie_q <= 1'b0;
        end else begin
            if (bus_sel)
                arm_q <= arming_wr;
            if (ctl_wr) begin
                we_q <= bus_wdata[CB_WE];
                re_q <= bus_wdata[CB_RE];
            end
            if (start_wr)
                ws_q <= 1'b1;
            else if (wr_done)
                ws_q <= 1'b0;
            if (start_rd)
                rs_q <= 1'b1;
            else if (rd_done)
                rs_q <= 1'b0;
            if (reg_wr && bus_off == OFF_ADR && !busy)
                adr_q <= bus_wdata[AW-1:0];
            if (rd_done)
                dat_q <= cell_rdata;
            else if (reg_wr && bus_off == OFF_DAT && !busy)
                dat_q <= bus_wdata;
            if (irq_wr) begin
                glb_q  <= bus_wdata[IB_GLB];
                eeie_q <= bus_wdata[IB_EEIE];
                mfie_q <= bus_wdata[IB_MFIE];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_off)
            OFF_ADR: bus_rdata[AW-1:0] = adr_q;
            OFF_DAT: bus_rdata = dat_q;
            OFF_CTL: begin
                bus_rdata[CB_WS] = ws_q;
                bus_rdata[CB_RS] = rs_q;
                bus_rdata[CB_WE] = we_q;
                bus_rdata[CB_RE] = re_q;
            end
            OFF_IRQ: begin
                bus_rdata[IB_GLB]  = glb_q;
                bus_rdata[IB_EEIE] = eeie_q;
                bus_rdata[IB_MFIE] = mfie_q;
                bus_rdata[IB_EEF]  = ee_f;
                bus_rdata[IB_MFF]  = mf_f;
            end
            default: bus_rdata = '0;
        endcase
    end

    assign irq_req = glb_q && eeie_q && mfie_q && ee_f && mf_f && stack_ok;

    AST_RD_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && bus_wdata[CB_RS] && !re_q && !busy) |=> !rs_q)
        else $error("read started without enable"); // R2
    AST_WR_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ws_q) |-> $past(arm_q && we_q))
        else $error("write started without a fresh enable"); // R5
    AST_BUSY_ADR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(adr_q)) else $error("address changed while busy"); // R8
    AST_START_CLEARS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done |=> (!ws_q && !busy)) else $error("write start not cleared"); // R7
endmodule

// File: tb/sim_nvb_ctrl.sv
module sim_nvb_ctrl;
    localparam int WRC = 16;
    localparam logic [1:0] A_ADR = 2'd0, A_DAT = 2'd1, A_CTL = 2'd2, A_IRQ = 2'd3;
    localparam logic [7:0] K_WS = 8'h01, K_RS = 8'h02, K_WE = 8'h04, K_RE = 8'h08;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_we = 1'b0;
    logic [1:0] bus_off = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       stack_ok = 1'b0, irq_ack = 1'b0;
    logic       irq_req, busy;

    int checks = 0;
    int errors = 0;
    logic [7:0] shadow [64];
    logic       known [64];

    always #5 clk = ~clk;

    nvb_ctrl #(.AW(6), .WR_CYCLES(WRC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_off(bus_off), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .stack_ok(stack_ok), .irq_ack(irq_ack), .irq_req(irq_req), .busy(busy)
    );

    function automatic logic exp_irq(input logic [7:0] r, input logic stk);
        return r[0] && r[1] && r[2] && r[4] && r[5] && stk;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] off, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_off = off; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] off, output logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_off = off;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic peek(input logic [1:0] off, output logic [7:0] d);
        bus_off = off;
        #1 d = bus_rdata;
    endtask

    task automatic wait_wr(output int n);
        logic [7:0] v;
        n = 0;
        peek(A_CTL, v);
        while (v[0] && n < 100) begin
            @(negedge clk);
            n++;
            peek(A_CTL, v);
        end
    endtask

    task automatic write_byte(input logic [5:0] a, input logic [7:0] d);
        int n;
        wr(A_ADR, {2'b0, a});
        wr(A_DAT, d);
        wr(A_CTL, K_WE);
        wr(A_CTL, K_WE | K_WS);
        wait_wr(n);
        chk("R7 write duration lower", 32'(n >= WRC + 1), 1);
        chk("R7 write duration upper", 32'(n <= 2 * WRC), 1);
        shadow[a] = d;
        known[a] = 1'b1;
        wr(A_CTL, 8'h00);
    endtask

    task automatic read_byte(input logic [5:0] a, output logic [7:0] d);
        wr(A_ADR, {2'b0, a});
        wr(A_CTL, K_RE);
        wr(A_CTL, K_RE | K_RS);
        @(negedge clk);
        @(negedge clk);
        peek(A_DAT, d);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, v2;
        int n;
        void'($urandom(32'd7321));
        for (int i = 0; i < 64; i++) known[i] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        peek(A_ADR, v); chk("R1 address", v, 8'h00);
        peek(A_CTL, v); chk("R1 control", v, 8'h00);
        peek(A_IRQ, v); chk("R1 interrupt reg", v, 8'h00);
        chk("R1 busy", busy, 0);
        chk("R1 irq_req", irq_req, 0);

        // R5: write start without enable, and both bits in one write
        wr(A_ADR, 8'h05); wr(A_DAT, 8'h3C);
        wr(A_CTL, K_WS);
        peek(A_CTL, v); chk("R5 ws without we", v[0], 0);
        chk("R5 busy stays 0", busy, 0);
        wr(A_CTL, K_WE | K_WS);
        peek(A_CTL, v); chk("R5 we and ws together", v[0], 0);

        // R6: intervening accesses break the pairing
        wr(A_CTL, K_WE); rd(A_ADR, v2); wr(A_CTL, K_WE | K_WS);
        peek(A_CTL, v); chk("R6 read in between", v[0], 0);
        wr(A_CTL, K_WE); wr(A_DAT, 8'h3C); wr(A_CTL, K_WE | K_WS);
        peek(A_CTL, v); chk("R6 write in between", v[0], 0);
        wr(A_CTL, 8'h00);

        // R2 + R4: read start with no enable
        peek(A_DAT, v2);
        wr(A_CTL, K_RS);
        peek(A_CTL, v); chk("R2 rs stays 0", v[1], 0);
        chk("R2 busy stays 0", busy, 0);
        rd(A_CTL, v); rd(A_ADR, v);
        peek(A_DAT, v); chk("R4 data kept", v, v2);

        // R7: directed write then R3 read with exact timing
        write_byte(6'd5, 8'hA7);
        wr(A_ADR, 8'h05); wr(A_DAT, 8'h00);
        wr(A_CTL, K_RE);
        wr(A_CTL, K_RE | K_RS);
        peek(A_CTL, v); chk("R3 rs set after start", v[1], 1);
        chk("R3 busy after start", busy, 1);
        @(negedge clk);
        peek(A_CTL, v); chk("R3 rs still set at 1 clock", v[1], 1);
        @(negedge clk);
        peek(A_CTL, v); chk("R3 rs clear at 2 clocks", v[1], 0);
        chk("R3 busy clear at 2 clocks", busy, 0);
        peek(A_DAT, v); chk("R3 read data", v, 8'hA7);
        rd(A_ADR, v2); peek(A_DAT, v2); chk("R4 data kept after access", v2, 8'hA7);

        // R8: writes during busy
        wr(A_ADR, 8'h09); wr(A_DAT, 8'h5E);
        wr(A_CTL, K_WE); wr(A_CTL, K_WE | K_WS);
        wr(A_ADR, 8'h11); wr(A_DAT, 8'hFF); wr(A_CTL, K_RE | K_RS);
        peek(A_ADR, v); chk("R8 address held", v, 8'h09);
        peek(A_DAT, v); chk("R8 data held", v, 8'h5E);
        peek(A_CTL, v); chk("R8 control: ws kept, enables written", v, 8'h09);
        wait_wr(n);
        shadow[9] = 8'h5E; known[9] = 1'b1;
        read_byte(6'd9, v); chk("R8 stored byte", v, 8'h5E);

        // R12: both start bits, write wins
        wr(A_ADR, 8'h21); wr(A_DAT, 8'hC3);
        wr(A_CTL, K_RE | K_WE);
        wr(A_CTL, K_RE | K_WE | K_WS | K_RS);
        peek(A_CTL, v); chk("R12 write taken, read not", v, 8'h0D);
        wait_wr(n);
        shadow[33] = 8'hC3; known[33] = 1'b1;
        wr(A_CTL, 8'h00);

        // R9: flag set collides with a software clear
        wr(A_ADR, 8'h02); wr(A_DAT, 8'h66);
        wr(A_CTL, K_WE); wr(A_CTL, K_WE | K_WS);
        while (busy) wr(A_IRQ, 8'h07);
        shadow[2] = 8'h66; known[2] = 1'b1;
        peek(A_IRQ, v); chk("R9 flags set despite clear", v, 8'h37);

        // R10: request gating
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 2; s++) begin
                wr(A_IRQ, 8'h30 | 8'(c));
                stack_ok = s[0];
                #1 chk("R10 irq_req", irq_req, exp_irq(8'h30 | 8'(c), s[0]));
            end
        end

        // R11: acknowledge clears only the shared flag
        wr(A_IRQ, 8'h37);
        irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
        peek(A_IRQ, v); chk("R11 only mf cleared", v, 8'h17);
        chk("R11 irq_req dropped", irq_req, 0);
        wr(A_IRQ, 8'h07);
        peek(A_IRQ, v); chk("R11 software clears ee", v, 8'h07);
        stack_ok = 1'b0;

        // random writes, some with a broken pairing
        for (int i = 0; i < 24; i++) begin
            logic [5:0] a;
            logic [7:0] d;
            a = 6'($urandom % 64);
            d = 8'($urandom);
            if (($urandom % 3) == 0) begin
                wr(A_ADR, {2'b0, a}); wr(A_DAT, d);
                wr(A_CTL, K_WE); rd(A_IRQ, v2); wr(A_CTL, K_WE | K_WS);
                peek(A_CTL, v); chk("R6 random refusal", v[0], 0);
                wr(A_CTL, 8'h00);
            end else begin
                write_byte(a, d);
            end
        end
        for (int a = 0; a < 64; a++) begin
            if (known[a]) begin
                read_byte(6'(a), v);
                chk("R3 readback", v, shadow[a]);
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule